// File: doc/BRIEF.md
# Windowed Memory Address and Element Unpack

This block sits between an address register and a 1024-word by 32-bit block RAM. It turns a 16-bit address value into a RAM word address and then extracts one element from the word that the RAM returns. The top two address bits pick one of four fixed element widths: 32, 16, 8 or 4 bits. The same RAM therefore appears as 1024 words, 2048 halfwords, 4096 bytes or 8192 nibbles. Software never issues a special instruction for packed data. It only picks an address in the matching window.

The offset is applied by XOR, not by addition, so no carry chain is needed. When the XOR enable is set, a 10-bit immediate is XORed into the base. This gives the same result as an add only when the base has zero in the bits the immediate can touch, so software must keep its data groups aligned to a power of two.

Requests enter on a valid/ready port, and results leave on a valid/ready port. Back-pressure works as follows. While the output holds a result that is not taken, the whole pipeline freezes: `in_ready` is low, the RAM read strobe stays low, and the result holds steady. The RAM is expected to register its read data one cycle after `ram_rd` and to keep that data until the next read.

Top module: `wmu_top`

## Requirements
- R1: The effective address bits [15:14] select the window: 00 for 32-bit elements, 01 for 16-bit, 10 for 8-bit, 11 for 4-bit. `out_width` carries this 2-bit code with each result.
- R2: With `in_xor_en`=1 the effective address is `in_base` XOR the zero-extended `in_imm`. With `in_xor_en`=0 it is `in_base` unchanged. Bits [15:10] of the base are never altered, so there is no carry.
- R3: `ram_addr` equals the effective address shifted right by the window code (0, 1, 2 or 3) and truncated to 10 bits. Bit 13 never affects it.
- R4: The effective address bits below the shift pick the lane: bit 0 for halfwords, bits [1:0] for bytes, bits [2:0] for nibbles. Lane 0 is the least significant part of the word.
- R5: A 16-bit element is sign-extended to 32 bits. An 8-bit or 4-bit element is zero-extended. A 32-bit element is returned unchanged.
- R6: Each accepted request causes exactly one `ram_rd` pulse and exactly one result. Both come out in request order.
- R7: With `out_ready` held high, a request accepted at a rising edge shows its result on `out_valid` after the fourth rising edge counted from acceptance.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid`=1 and `out_ready`=0, the outputs `out_valid`, `out_data` and `out_width` hold their values and `ram_rd` stays low.
- R9: While `rst_n` is low, and immediately after reset, `out_valid` and `ram_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request taken at this edge when also valid |
| in_base | input | 16 | Address register value |
| in_imm | input | 10 | Offset applied by XOR |
| in_xor_en | input | 1 | Apply the offset |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | 10 | RAM word address |
| ram_rdata | input | 32 | RAM word, one cycle after the read strobe, held until the next read |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Extracted and extended element |
| out_width | output | 2 | Window code of the result |

## Verification
The hardest case to reach is a stall that lands while a request sits in the RAM stage. In that case the returned RAM word must survive several cycles with no read strobe, and it must still be unpacked using the lane of its own request. The bench drives `out_ready` low on random cycles while a steady stream of random addresses flows through. These stalls repeatedly freeze words in every stage, and a behavioural queue model checks that no result is lost, duplicated or mismatched. A directed sweep before the random phase covers every window, every lane and both XOR settings. In that sweep bit 13 is set, which must have no effect.

// File: rtl/wmu_pkg.sv
package wmu_pkg;
  typedef enum logic [1:0] {
    WIN_32 = 2'd0,
    WIN_16 = 2'd1,
    WIN_8  = 2'd2,
    WIN_4  = 2'd3
  } win_e;
  localparam int unsigned NUM_WIN = 4;
endpackage

// File: rtl/wmu_xor_stage.sv
module wmu_xor_stage #(
  parameter int unsigned AW = 16,
  parameter int unsigned IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_valid,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] imm,
  input  logic          xor_en,
  output logic          eff_valid,
  output logic [AW-1:0] eff_q
);
  logic [AW-1:0] mask;
  assign mask = xor_en ? {{(AW-IW){1'b0}}, imm} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_valid <= 1'b0;
      eff_q     <= '0;
    end else if (adv) begin
      eff_valid <= in_valid;
      eff_q     <= base ^ mask;
    end
  end

  // R2: bits above the immediate pass untouched (no carry into the window field)
  a_r2_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid) |=> (eff_q[AW-1:IW] == $past(base[AW-1:IW])));

  // R2: with the enable clear, the base arrives unchanged
  a_r2_plain_base: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid && !xor_en) |=> (eff_q == $past(base)));
endmodule

// File: rtl/wmu_translate.sv
module wmu_translate
  import wmu_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned RAW = 10,
  parameter int unsigned LW  = 3
) (
  input  logic [AW-1:0]  eff,
  output logic [RAW-1:0] word_addr,
  output win_e           win,
  output logic [LW-1:0]  lane
);
  logic [RAW-1:0] cand [NUM_WIN];
  logic           unused_hi;

  assign win = win_e'(eff[AW-1 -: 2]);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_shift
    assign cand[g] = eff[g +: RAW];
  end

  assign word_addr = cand[win];
  assign unused_hi = ^eff[AW-3:RAW+LW];

  always_comb begin
    lane = '0;
    unique case (win)
      WIN_32: lane = '0;
      WIN_16: lane = {{(LW-1){1'b0}}, eff[0]};
      WIN_8:  lane = {{(LW-2){1'b0}}, eff[1:0]};
      WIN_4:  lane = eff[LW-1:0];
    endcase
  end
endmodule

// File: rtl/wmu_unpack.sv
module wmu_unpack
  import wmu_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 3
) (
  input  logic [DW-1:0] word,
  input  win_e          win,
  input  logic [LW-1:0] lane,
  output logic [DW-1:0] elem
);
  localparam int unsigned SHW = $clog2(DW);

  logic [SHW-1:0] sh;
  logic [DW-1:0]  sw;

  always_comb begin
    sh = '0;
    unique case (win)
      WIN_32: sh = '0;
      WIN_16: sh = SHW'({lane[0], 4'b0});
      WIN_8:  sh = SHW'({lane[1:0], 3'b0});
      WIN_4:  sh = SHW'({lane, 2'b0});
    endcase
  end

  assign sw = word >> sh;

  always_comb begin
    elem = sw;
    unique case (win)
      WIN_32: elem = sw;
      WIN_16: elem = {{(DW-16){sw[15]}}, sw[15:0]};
      WIN_8:  elem = {{(DW-8){1'b0}}, sw[7:0]};
      WIN_4:  elem = {{(DW-4){1'b0}}, sw[3:0]};
    endcase
  end
endmodule

// File: rtl/wmu_top.sv
module wmu_top
  import wmu_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned IW  = 10,
  parameter int unsigned RAW = 10,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [AW-1:0]  in_base,
  input  logic [IW-1:0]  in_imm,
  input  logic           in_xor_en,
  output logic           ram_rd,
  output logic [RAW-1:0] ram_addr,
  input  logic [DW-1:0]  ram_rdata,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic [1:0]     out_width
);
  localparam int unsigned LW = $clog2(DW / 4);

  logic           adv;
  logic           s1_valid;
  logic [AW-1:0]  s1_eff;
  logic [RAW-1:0] t_addr;
  win_e           t_win;
  logic [LW-1:0]  t_lane;
  logic           s2_valid;
  logic [RAW-1:0] s2_addr;
  win_e           s2_win;
  logic [LW-1:0]  s2_lane;
  logic           s3_valid;
  win_e           s3_win;
  logic [LW-1:0]  s3_lane;
  logic [DW-1:0]  elem;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  wmu_xor_stage #(.AW(AW), .IW(IW)) u_xor (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
    .base(in_base), .imm(in_imm), .xor_en(in_xor_en),
    .eff_valid(s1_valid), .eff_q(s1_eff)
  );

  wmu_translate #(.AW(AW), .RAW(RAW), .LW(LW)) u_xlate (
    .eff(s1_eff), .word_addr(t_addr), .win(t_win), .lane(t_lane)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_addr  <= '0;
      s2_win   <= WIN_32;
      s2_lane  <= '0;
      s3_valid <= 1'b0;
      s3_win   <= WIN_32;
      s3_lane  <= '0;
    end else if (adv) begin
      s2_valid <= s1_valid;
      s2_addr  <= t_addr;
      s2_win   <= t_win;
      s2_lane  <= t_lane;
      s3_valid <= s2_valid;
      s3_win   <= s2_win;
      s3_lane  <= s2_lane;
    end
  end

  assign ram_rd   = s2_valid && adv;
  assign ram_addr = s2_addr;

  wmu_unpack #(.DW(DW), .LW(LW)) u_unpack (
    .word(ram_rdata), .win(s3_win), .lane(s3_lane), .elem(elem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_width <= '0;
    end else if (adv) begin
      out_valid <= s3_valid;
      out_data  <= elem;
      out_width <= s3_win;
    end
  end

  // R8: a stalled result is held steady
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_width)));

  // R8: no RAM read while the output is stalled
  a_r8_no_read_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !ram_rd);

  // R5: halfword results are sign-extended
  a_r5_half_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_width == 2'd1) |-> (out_data[DW-1:16] == {(DW-16){out_data[15]}}));

  // R5: byte results are zero-extended
  a_r5_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_width == 2'd2) |-> (out_data[DW-1:8] == '0));

  // R5: nibble results are zero-extended
  a_r5_nib_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_width == 2'd3) |-> (out_data[DW-1:4] == '0));
endmodule

// File: tb/wmu_top_bench.sv
`timescale 1ns/1ps
module wmu_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_base = '0;
  logic [9:0]  in_imm = '0;
  logic        in_xor_en = 1'b0;
  logic        ram_rd;
  logic [9:0]  ram_addr;
  logic [31:0] ram_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [1:0]  out_width;

  always #2 clk = ~clk;

  wmu_top u_wmu_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_imm(in_imm), .in_xor_en(in_xor_en),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_width(out_width)
  );

  logic [31:0] mem [1024];
  always_ff @(posedge clk) if (ram_rd) ram_rdata <= mem[ram_addr];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit lat_mode = 1'b0;
  logic [31:0] exp_data_q [$];
  logic [1:0]  exp_wid_q [$];
  int          exp_cyc_q [$];
  logic [9:0]  exp_addr_q [$];

  function automatic logic [31:0] ref_elem(input logic [15:0] b, input logic [9:0] im,
                                           input bit xe, output logic [9:0] wa,
                                           output logic [1:0] wc);
    int unsigned eff, w, lane, bits;
    logic [31:0] v;
    eff  = b ^ (xe ? im : 10'd0);
    w    = eff >> 14;
    wc   = 2'(w);
    wa   = 10'(eff >> w);
    lane = eff & ((1 << w) - 1);
    bits = 32 >> w;
    v    = mem[wa] >> (lane * bits);
    if (bits < 32) v = v & ((32'd1 << bits) - 1);
    if (bits == 16 && v[15]) v = v | 32'hFFFF0000;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit iv, input logic [15:0] b, input logic [9:0] im,
                      input bit xe, input bit ordy, output bit fired);
    logic [9:0] wa;
    logic [1:0] wc;
    logic [31:0] d;
    bit of;
    @(negedge clk);
    cyc++;
    if (out_valid) begin
      if (exp_data_q.size() == 0) chk(1'b0, "R6", "unexpected result", out_data, 0);
      else begin
        chk(out_data == exp_data_q[0], "R5", "element value", out_data, exp_data_q[0]);
        chk(out_width == exp_wid_q[0], "R1", "width code", 32'(out_width), 32'(exp_wid_q[0]));
        if (lat_mode)
          chk(cyc - exp_cyc_q[0] == 4, "R7", "latency", cyc - exp_cyc_q[0], 4);
      end
    end
    in_valid = iv; in_base = b; in_imm = im; in_xor_en = xe; out_ready = ordy;
    #1;
    of    = out_valid && ordy;
    fired = iv && (!out_valid || ordy);
    chk(in_ready == (!out_valid || ordy), "R8", "in_ready", 32'(in_ready), 32'(!out_valid || ordy));
    if (out_valid && !ordy) chk(!ram_rd, "R8", "read while stalled", 32'(ram_rd), 0);
    if (ram_rd) begin
      if (exp_addr_q.size() == 0) chk(1'b0, "R6", "unexpected read", 32'(ram_addr), 0);
      else begin
        chk(ram_addr == exp_addr_q[0], "R3", "ram address", 32'(ram_addr), 32'(exp_addr_q[0]));
        void'(exp_addr_q.pop_front());
      end
    end
    if (of && exp_data_q.size() != 0) begin
      void'(exp_data_q.pop_front()); void'(exp_wid_q.pop_front()); void'(exp_cyc_q.pop_front());
    end
    if (fired) begin
      d = ref_elem(b, im, xe, wa, wc);
      exp_data_q.push_back(d); exp_wid_q.push_back(wc);
      exp_cyc_q.push_back(cyc); exp_addr_q.push_back(wa);
    end
  endtask

  task automatic send(input logic [15:0] b, input logic [9:0] im, input bit xe);
    bit f;
    f = 1'b0;
    while (!f) step(1'b1, b, im, xe, 1'b1, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit f;
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E3779B1) ^ (i << 19) ^ 32'h5A0F_C3A5;
    repeat (3) @(negedge clk);
    // R9: reset state, including with a request presented
    in_valid = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R9", "out_valid in reset", 32'(out_valid), 0);
    chk(!ram_rd, "R9", "ram_rd in reset", 32'(ram_rd), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R9", "out_valid after reset", 32'(out_valid), 0);
    chk(!ram_rd, "R9", "ram_rd after reset", 32'(ram_rd), 0);

    // R7: single request latency with no stall
    lat_mode = 1'b1;
    send(16'h8123, 10'h0, 1'b0);
    repeat (6) step(1'b0, '0, '0, 1'b0, 1'b1, f);
    lat_mode = 1'b0;

    // R1 R2 R3 R4 R5: every window, every lane, both XOR settings, bit 13 set
    for (int w = 0; w < 4; w++) begin
      for (int ln = 0; ln < (1 << w); ln++) begin
        for (int xe = 0; xe < 2; xe++) begin
          int unsigned r, bb, ii;
          r = (w * 97 + ln * 13 + 5) & 1023;
          if (xe == 0) begin
            bb = (w << 14) | 16'h2000 | ((r << w) & 16'h1FFF) | ln;
            ii = 10'h3FF;
          end else begin
            bb = (w << 14) | 16'h2000 | ((r << w) & 16'h1FFF & ~((1 << (w + 2)) - 1));
            ii = ln | (3 << w);
          end
          send(16'(bb), 10'(ii), xe[0]);
        end
      end
    end
    repeat (8) step(1'b0, '0, '0, 1'b0, 1'b1, f);

    // R6 R8: random stream with random back-pressure
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 4) != 0, 16'($urandom), 10'($urandom), 1'($urandom),
           ($urandom % 10) < 6, f);
    end
    repeat (12) step(1'b0, '0, '0, 1'b0, 1'b1, f);
    // R6: every request produced exactly one read and one result
    chk(exp_data_q.size() == 0, "R6", "results left over", exp_data_q.size(), 0);
    chk(exp_addr_q.size() == 0, "R6", "reads left over", exp_addr_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule